// File: doc/BRIEF.md
# Power-Management Event and Timer Register Block

This block holds the power-management event state of a system controller. A free-running timer advances on an externally supplied tick enable, and four event sources (timer overflow, global release, power button, alarm) latch into a status register. Each status bit is cleared by writing a 1 to it. Software sets mask bits in an enable register. A level-sensitive system control interrupt stays asserted while any enabled event is pending.

A control register stores software's sleep configuration. It also carries a sleep-go strobe bit. That bit is never stored. When it is written together with the soft-off sleep type, it produces a single-cycle power-off request. Access goes through a simple register bus that accepts 16-bit (word) and 32-bit (dword) transfers. Read data returns one cycle after the request.

Top module: `pm_evt_regs`

## Requirements
- R1: After a synchronous active-high reset, the status, enable and control registers read 0, the timer reads 0, and the interrupt and power-off outputs are low.
- R2: The timer is TMR_W bits wide (default 24) and advances by one in each cycle where tickEn is high. It wraps to zero after its all-ones value. A dword read at offset 0x08 returns it zero-extended to 32 bits.
- R3: Word reads return the status register at offset 0x00, the enable register at 0x02 and the control register at 0x04. Every other offset or transfer size reads 0. Dword writes and word writes to any other offset change no register.
- R4: Only the low 6 bits of busAddr take part in decode. For example, address 0x42 reaches the enable register.
- R5: A word write to the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Status bits other than 0, 5, 8 and 10 always read 0.
- R6: A one-cycle pulse on evtGbl, evtPwrBtn or evtRtc sets status bit 5, 8 or 10 respectively. If a pulse and a clearing write to the same bit fall in the same cycle, the bit ends up set.
- R7: Status bit 0 is set in each cycle where the timer's most significant bit changes value, in both the rising and the wrapping direction.
- R8: sciOut is high exactly when at least one of bits 0, 5, 8 or 10 is set in both the status and the enable register. The other enable bits have no effect on it.
- R9: A word write to the control register stores every written bit except bit 13, which always reads back 0. The enable register stores all 16 written bits.
- R10: A control write with bit 13 set and bits 11:10 equal to 00 raises powerOffReq for exactly one cycle, starting at the clock edge that takes the write. With any other value in bits 11:10, or with bit 13 clear, powerOffReq stays low.
- R11: Each read request produces rdValid high for one cycle after the request edge, and rdData holds the value as it stood at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busRd | input | 1 | Read request, one cycle |
| busWr | input | 1 | Write request, one cycle |
| busDword | input | 1 | 1 = 32-bit transfer, 0 = 16-bit transfer |
| busAddr | input | ADDR_W | Byte address; only the low 6 bits are decoded |
| busWdata | input | 32 | Write data; word writes use bits 15:0 |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after busRd |
| tickEn | input | 1 | Timer advance enable at the timer rate |
| evtRtc | input | 1 | Alarm event pulse |
| evtPwrBtn | input | 1 | Power-button event pulse |
| evtGbl | input | 1 | Global-release event pulse |
| sciOut | output | 1 | Level-sensitive system control interrupt |
| powerOffReq | output | 1 | Soft power-off request pulse |

## Verification
The bench instantiates the block with TMR_W set to 8, so the timer's top bit flips every 128 ticks and the timer wraps every 256. Both overflow directions can then be reached and checked in a few hundred cycles. At the default width that would take millions of ticks. ADDR_W stays at 16, which leaves room for addresses with bits set above the 6 decoded bits.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int REG_W = 16;
  localparam int BUS_W = 32;
  localparam int OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_STS = 6'h00;
  localparam logic [OFF_W-1:0] OFF_EN  = 6'h02;
  localparam logic [OFF_W-1:0] OFF_CTL = 6'h04;
  localparam logic [OFF_W-1:0] OFF_TMR = 6'h08;

  // event bit positions shared by status and enable
  localparam int BIT_TMR = 0;
  localparam int BIT_GBL = 5;
  localparam int BIT_PWR = 8;
  localparam int BIT_RTC = 10;

  // control fields
  localparam int BIT_SLP_GO = 13;
  localparam int TYP_LO     = 10;
  localparam logic [1:0] TYP_SOFT_OFF = 2'b00;

  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) | (1 << BIT_PWR) | (1 << BIT_RTC));

  typedef struct packed {
    logic             stsWr;
    logic             enWr;
    logic             ctlWr;
    logic             rdSts;
    logic             rdEn;
    logic             rdCtl;
    logic             rdTmr;
    logic             rdAny;
    logic [REG_W-1:0] wdata;
  } pmStrobe_t;
endpackage

// File: rtl/pm_evt_ctrl.sv
module pm_evt_ctrl
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busDword,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output pmStrobe_t         stb
);
  logic [OFF_W-1:0] offset;
  logic             wordWr;
  logic             wordRd;
  logic             dwordRd;

  always_comb begin
    offset  = busAddr[OFF_W-1:0];
    wordWr  = busWr & ~busDword;
    wordRd  = busRd & ~busDword;
    dwordRd = busRd & busDword;

    stb.stsWr = wordWr & (offset == OFF_STS);
    stb.enWr  = wordWr & (offset == OFF_EN);
    stb.ctlWr = wordWr & (offset == OFF_CTL);
    stb.rdSts = wordRd & (offset == OFF_STS);
    stb.rdEn  = wordRd & (offset == OFF_EN);
    stb.rdCtl = wordRd & (offset == OFF_CTL);
    stb.rdTmr = dwordRd & (offset == OFF_TMR);
    stb.rdAny = busRd;
    stb.wdata = busWdata[REG_W-1:0];
  end

  // R3: at most one register is written per cycle
  assert_one_write_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.stsWr, stb.enWr, stb.ctlWr}));

  // R3: at most one read source is selected
  assert_one_read_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.rdSts, stb.rdEn, stb.rdCtl, stb.rdTmr}));
endmodule

// File: rtl/pm_evt_dp.sv
module pm_evt_dp
  import pm_evt_pkg::*;
#(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  pmStrobe_t        stb,
  input  logic             tickEn,
  input  logic             evtRtc,
  input  logic             evtPwrBtn,
  input  logic             evtGbl,
  output logic [BUS_W-1:0] rdData,
  output logic             rdValid,
  output logic             sciOut,
  output logic             powerOffReq
);
  localparam int MSB = TMR_W - 1;

  logic [TMR_W-1:0] tmrCnt;
  logic [REG_W-1:0] stsReg;
  logic [REG_W-1:0] enReg;
  logic [REG_W-1:0] ctlReg;

  logic             msbFlip;
  logic [REG_W-1:0] setVec;
  logic [REG_W-1:0] clrVec;
  logic [REG_W-1:0] stsNext;
  logic [REG_W-1:0] ctlKeep;
  logic             sleepGo;
  logic [BUS_W-1:0] rdMux;

  always_comb begin
    // the top bit flips when every lower bit is one and the timer ticks
    msbFlip = tickEn & (&tmrCnt[MSB-1:0]);

    setVec          = '0;
    setVec[BIT_TMR] = msbFlip;
    setVec[BIT_GBL] = evtGbl;
    setVec[BIT_PWR] = evtPwrBtn;
    setVec[BIT_RTC] = evtRtc;

    clrVec  = stb.stsWr ? stb.wdata : '0;
    stsNext = ((stsReg & ~clrVec) | setVec) & EVT_MASK;

    ctlKeep             = stb.wdata;
    ctlKeep[BIT_SLP_GO] = 1'b0;
    sleepGo = stb.ctlWr & stb.wdata[BIT_SLP_GO] &
              (stb.wdata[TYP_LO +: 2] == TYP_SOFT_OFF);

    rdMux = '0;
    if (stb.rdSts)      rdMux = BUS_W'(stsReg);
    else if (stb.rdEn)  rdMux = BUS_W'(enReg);
    else if (stb.rdCtl) rdMux = BUS_W'(ctlReg);
    else if (stb.rdTmr) rdMux = BUS_W'(tmrCnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmrCnt      <= '0;
      stsReg      <= '0;
      enReg       <= '0;
      ctlReg      <= '0;
      rdData      <= '0;
      rdValid     <= 1'b0;
      powerOffReq <= 1'b0;
    end else begin
      if (tickEn) tmrCnt <= tmrCnt + 1'b1;
      stsReg <= stsNext;
      if (stb.enWr)  enReg  <= stb.wdata;
      if (stb.ctlWr) ctlReg <= ctlKeep;
      rdValid     <= stb.rdAny;
      if (stb.rdAny) rdData <= rdMux;
      powerOffReq <= sleepGo;
    end
  end

  assign sciOut = |(stsReg & enReg & EVT_MASK);

  // R7: a change of the timer's top bit leaves the overflow flag set
  assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (tmrCnt[MSB] != $past(tmrCnt[MSB])) |-> stsReg[BIT_TMR]);

  // R6: an event pulse sets its status bit on the next edge
  assert_pwr_set_R6: assert property (@(posedge clk) disable iff (rst)
    evtPwrBtn |=> stsReg[BIT_PWR]);

  // R5: a set bit stays set unless a clearing write targets it
  assert_sts_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (stsReg[BIT_PWR] && !(stb.stsWr && stb.wdata[BIT_PWR])) |=> stsReg[BIT_PWR]);

  // R8: an enabled event raises the interrupt
  assert_sci_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (evtRtc && enReg[BIT_RTC] && !stb.enWr) |=> sciOut);

  // R10: the power-off request lasts a single cycle
  assert_off_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    powerOffReq |=> !powerOffReq);

  // R10: other sleep types leave the request low
  assert_off_type_R10: assert property (@(posedge clk) disable iff (rst)
    (stb.ctlWr && stb.wdata[TYP_LO +: 2] != TYP_SOFT_OFF) |=> !powerOffReq);

  // R11: each read request is answered on the next cycle
  assert_rd_valid_R11: assert property (@(posedge clk) disable iff (rst)
    stb.rdAny |=> rdValid);
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
#(
  parameter int TMR_W  = 24,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busDword,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       rdData,
  output logic              rdValid,
  input  logic              tickEn,
  input  logic              evtRtc,
  input  logic              evtPwrBtn,
  input  logic              evtGbl,
  output logic              sciOut,
  output logic              powerOffReq
);
  pmStrobe_t stb;

  pm_evt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .busRd    (busRd),
    .busWr    (busWr),
    .busDword (busDword),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .stb      (stb)
  );

  pm_evt_dp #(.TMR_W(TMR_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .tickEn      (tickEn),
    .evtRtc      (evtRtc),
    .evtPwrBtn   (evtPwrBtn),
    .evtGbl      (evtGbl),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .sciOut      (sciOut),
    .powerOffReq (powerOffReq)
  );
endmodule

// File: tb/pm_evt_regs_bench.sv
module pm_evt_regs_bench;
  localparam int TMR_W = 8;
  localparam int TMR_MOD = 1 << TMR_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic        busDword = 1'b0;
  logic [15:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        tickEn = 1'b0;
  logic        evtRtc = 1'b0;
  logic        evtPwrBtn = 1'b0;
  logic        evtGbl = 1'b0;
  logic        sciOut;
  logic        powerOffReq;

  int total = 0;
  int bad = 0;
  int tcnt = 0;
  int offPulses = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  pm_evt_regs #(.TMR_W(TMR_W), .ADDR_W(16)) u_pm_evt_regs (
    .clk(clk), .rst(rst), .busRd(busRd), .busWr(busWr), .busDword(busDword),
    .busAddr(busAddr), .busWdata(busWdata), .rdData(rdData), .rdValid(rdValid),
    .tickEn(tickEn), .evtRtc(evtRtc), .evtPwrBtn(evtPwrBtn), .evtGbl(evtGbl),
    .sciOut(sciOut), .powerOffReq(powerOffReq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: compares every returned read against the queue head
  always @(negedge clk) begin
    if (powerOffReq) offPulses++;
    if (rdValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R11 unexpected read data", rdData, 32'h0);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        chk(rdData === it.val, it.tag, rdData, it.val);
      end
    end
  end

  task automatic rdReq(input logic [15:0] a, input bit dw, input logic [31:0] exp,
                       input string tag);
    @(negedge clk);
    busRd = 1'b1; busDword = dw; busAddr = a;
    expQ.push_back('{val: exp, tag: tag});
    @(negedge clk);
    busRd = 1'b0; busDword = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input bit dw, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busDword = dw; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busDword = 1'b0;
  endtask

  task automatic evt(input bit r, input bit p, input bit g);
    @(negedge clk);
    evtRtc = r; evtPwrBtn = p; evtGbl = g;
    @(negedge clk);
    evtRtc = 1'b0; evtPwrBtn = 1'b0; evtGbl = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
    tcnt += n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(sciOut == 1'b0, "R1 sci after reset", 32'(sciOut), 32'h0);
    chk(powerOffReq == 1'b0, "R1 poweroff after reset", 32'(powerOffReq), 32'h0);
    rdReq(16'h00, 0, 32'h0, "R1 status reset");
    rdReq(16'h02, 0, 32'h0, "R1 enable reset");
    rdReq(16'h04, 0, 32'h0, "R1 control reset");
    rdReq(16'h08, 1, 32'h0, "R1 timer reset");

    // R2: timer counts ticks, dword read zero-extended
    tick(5);
    rdReq(16'h08, 1, 32'(tcnt), "R2 timer after 5 ticks");
    rdReq(16'h08, 0, 32'h0, "R3 word read of timer offset");

    // R8 / R5: power button enabled
    wr(16'h02, 0, 32'h0100);
    rdReq(16'h02, 0, 32'h0100, "R9 enable readback");
    evt(0, 1, 0);
    chk(sciOut == 1'b1, "R8 sci on enabled power button", 32'(sciOut), 32'h1);
    rdReq(16'h00, 0, 32'h0100, "R6 power button sets bit 8");
    wr(16'h00, 0, 32'h0001);
    rdReq(16'h00, 0, 32'h0100, "R5 zero bits leave status");
    wr(16'h00, 0, 32'h0100);
    rdReq(16'h00, 0, 32'h0000, "R5 one clears status bit");
    chk(sciOut == 1'b0, "R8 sci drops after clear", 32'(sciOut), 32'h0);

    // R6 / R8: masking by enable
    evt(1, 0, 1);
    rdReq(16'h00, 0, 32'h0420, "R6 alarm and global set");
    chk(sciOut == 1'b0, "R8 sci masked", 32'(sciOut), 32'h0);
    wr(16'h02, 0, 32'hFBDF);
    chk(sciOut == 1'b0, "R8 non-event enables ignored", 32'(sciOut), 32'h0);
    wr(16'h02, 0, 32'h0020);
    chk(sciOut == 1'b1, "R8 sci on enabled global", 32'(sciOut), 32'h1);
    wr(16'h00, 0, 32'hFFFF);
    rdReq(16'h00, 0, 32'h0000, "R5 clear all");

    // R6: set wins over a same-cycle clear
    @(negedge clk);
    evtPwrBtn = 1'b1; busWr = 1'b1; busDword = 1'b0; busAddr = 16'h00; busWdata = 32'h0100;
    @(negedge clk);
    evtPwrBtn = 1'b0; busWr = 1'b0;
    rdReq(16'h00, 0, 32'h0100, "R6 set beats clear");
    wr(16'h00, 0, 32'h0100);
    rdReq(16'h00, 0, 32'h0000, "R5 status clean again");

    // R4 / R3: offset masking and ignored accesses
    wr(16'h0042, 0, 32'h1234);
    rdReq(16'h0002, 0, 32'h1234, "R4 write via 0x42");
    rdReq(16'h00C2, 0, 32'h1234, "R4 read via 0xC2");
    wr(16'h000A, 0, 32'hFFFF);
    rdReq(16'h000A, 0, 32'h0, "R3 unmapped offset reads zero");
    wr(16'h0002, 1, 32'h0000ABCD);
    rdReq(16'h0002, 0, 32'h1234, "R3 dword write ignored");
    rdReq(16'h0000, 1, 32'h0, "R3 dword read of status is zero");
    rdReq(16'h0004, 0, 32'h0, "R3 control untouched");

    // R9 / R10: control register and power-off
    wr(16'h04, 0, 32'h2C05);
    rdReq(16'h04, 0, 32'h0C05, "R9 strobe bit not stored");
    chk(offPulses == 0, "R10 no poweroff for type 11", 32'(offPulses), 32'h0);
    wr(16'h04, 0, 32'h2403);
    chk(offPulses == 0, "R10 no poweroff for type 01", 32'(offPulses), 32'h0);
    wr(16'h04, 0, 32'h0003);
    chk(offPulses == 0, "R10 no poweroff without strobe", 32'(offPulses), 32'h0);
    @(negedge clk);
    busWr = 1'b1; busAddr = 16'h04; busWdata = 32'h2003;
    @(negedge clk);
    busWr = 1'b0;
    chk(powerOffReq == 1'b1, "R10 poweroff raised", 32'(powerOffReq), 32'h1);
    @(negedge clk);
    chk(powerOffReq == 1'b0, "R10 poweroff one cycle", 32'(powerOffReq), 32'h0);
    chk(offPulses == 1, "R10 exactly one pulse", 32'(offPulses), 32'h1);
    rdReq(16'h04, 0, 32'h0003, "R9 control after strobe");

    // R7: overflow on top-bit rise and on wrap
    tick((TMR_MOD / 2) - 1 - tcnt);
    rdReq(16'h00, 0, 32'h0, "R7 no flag before top bit rises");
    tick(1);
    rdReq(16'h00, 0, 32'h0001, "R7 flag on top bit rise");
    chk(sciOut == 1'b0, "R8 overflow masked", 32'(sciOut), 32'h0);
    wr(16'h02, 0, 32'h0001);
    chk(sciOut == 1'b1, "R8 sci on enabled overflow", 32'(sciOut), 32'h1);
    wr(16'h00, 0, 32'h0001);
    chk(sciOut == 1'b0, "R8 sci drops after overflow clear", 32'(sciOut), 32'h0);
    tick((TMR_MOD / 2) - 1);
    rdReq(16'h00, 0, 32'h0, "R7 no flag before wrap");
    rdReq(16'h08, 1, 32'(TMR_MOD - 1), "R2 timer at all ones");
    tick(1);
    rdReq(16'h08, 1, 32'h0, "R2 timer wraps to zero");
    rdReq(16'h00, 0, 32'h0001, "R7 flag on wrap");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R11 all reads answered", 32'(expQ.size()), 32'h0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule